// File: doc/BRIEF.md
# Packed Signed Saturating Vector Adder

This block adds two 256-bit packed operands lane by lane as signed integers. Lane results that leave the signed range of their lane are clamped to the nearest limit instead of wrapping. An 8-bit code, presented with each operation, selects 8-bit or 16-bit lanes at run time. A 2-bit form select controls how many bits are computed and where the upper 128 result bits come from. They can be computed, forced to zero, or copied from the old destination register.

The block is a one-cycle execution stage inside a vector unit. The surrounding pipeline supplies both sources, the upper half of the old destination, the lane code, the form and a valid strobe. One clock later the block returns a registered 256-bit result, a valid flag and an error flag. The error flag marks an operation whose code or form is not defined.

Top module: `psat_vadd`

## Requirements
- R1: With lane_code 8'hEC, the datapath is 32 independent signed 8-bit lanes. A lane sum above +127 yields 8'h7F, and a lane sum below -128 yields 8'h80.
- R2: With lane_code 8'hED, the datapath is 16 independent signed 16-bit lanes. A lane sum above +32767 yields 16'h7FFF, and a lane sum below -32768 yields 16'h8000.
- R3: A lane sum inside the signed range is returned exactly. Operands of equal sign never produce a result of the opposite sign. No carry or clamp in one lane changes any other lane.
- R4: With form_sel 2'b00, all 256 result bits are lane sums of the two sources.
- R5: With form_sel 2'b01, result bits 127:0 are lane sums and bits 255:128 are zero.
- R6: With form_sel 2'b10, result bits 127:0 are lane sums and bits 255:128 equal old_dst_hi.
- R7: With form_sel 2'b11, or with a lane_code other than 8'hEC or 8'hED, the result is all zero and out_err is 1 in the same cycle as out_valid. Otherwise out_err is 0.
- R8: out_valid is 1 exactly one clock after a cycle with in_valid high, and the result appears on that same edge. After a cycle with in_valid low, out_valid is 0 and out_result keeps its previous value.
- R9: A synchronous active-high rst clears out_valid, out_err and out_result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| src_a | input | 256 | First packed source |
| src_b | input | 256 | Second packed source |
| old_dst_hi | input | 128 | Upper half of the old destination value |
| lane_code | input | 8 | Lane-size code: 8'hEC bytes, 8'hED words |
| form_sel | input | 2 | 00 full width, 01 zero upper, 10 keep upper, 11 reserved |
| out_valid | output | 1 | Registered result valid |
| out_result | output | 256 | Registered saturated result |
| out_err | output | 1 | Undefined code or form, set together with out_valid |

## Verification
The clocked properties assume that rst is driven to a known level on every clock edge. They also assume that the inputs are stable around each rising edge. The bench meets this by changing all inputs only on falling edges.

The keep-upper property assumes that old_dst_hi in the cycle of the strobe is the value that should reach the output. The bench therefore holds old_dst_hi together with the other operands for the whole strobe cycle.

Random lane values are drawn partly from the extremes 8'h7F, 8'h80, 8'h01 and 8'hFF, so that most operations exercise clamping. Undefined codes and forms are drawn only now and then.

// File: rtl/psat_pkg.sv
package psat_pkg;

  typedef enum logic [1:0] {
    FORM_FULL   = 2'b00,
    FORM_NARROW = 2'b01,
    FORM_MERGE  = 2'b10,
    FORM_RSVD   = 2'b11
  } form_e;

  localparam logic [7:0] CODE_BYTE = 8'hEC;
  localparam logic [7:0] CODE_WORD = 8'hED;

endpackage

// File: rtl/psat_lane.sv
module psat_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] raw;
  logic         ovf;

  always_comb begin
    raw = a + b;
    // overflow only when operands agree in sign and the raw sum disagrees
    ovf = (a[W-1] == b[W-1]) && (raw[W-1] != a[W-1]);
    if (ovf) y = a[W-1] ? MINV : MAXV;
    else     y = raw;
  end

  // R3: equal-sign operands keep their sign in the clamped result
  always_comb begin
    p_no_wrap_r3: assert (a[W-1] != b[W-1] || y[W-1] == a[W-1]);
  end

endmodule

// File: rtl/psat_lane_array.sv
module psat_lane_array #(
  parameter int DATA_W = 256,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);

  localparam int NLANES = DATA_W / LANE_W;

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    psat_lane #(.W(LANE_W)) u_lane (
      .a (a[i*LANE_W +: LANE_W]),
      .b (b[i*LANE_W +: LANE_W]),
      .y (y[i*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/psat_form_merge.sv
module psat_form_merge
  import psat_pkg::*;
#(
  parameter int DATA_W = 256
) (
  input  logic [DATA_W-1:0]          sum,
  input  logic [DATA_W-DATA_W/2-1:0] old_hi,
  input  logic [1:0]                 form_sel,
  input  logic                       code_ok,
  output logic [DATA_W-1:0]          res,
  output logic                       err
);

  localparam int HALF_W = DATA_W / 2;
  localparam int HI_W   = DATA_W - HALF_W;

  always_comb begin
    res = '0;
    err = 1'b0;
    case (form_e'(form_sel))
      FORM_FULL:   res = sum;
      FORM_NARROW: res = {{HI_W{1'b0}}, sum[HALF_W-1:0]};
      FORM_MERGE:  res = {old_hi, sum[HALF_W-1:0]};
      default:     err = 1'b1;
    endcase
    if (!code_ok) err = 1'b1;
    if (err) res = '0;
  end

  // R7: an error never leaks a partial result
  always_comb begin
    p_err_blank_r7: assert (!err || res == '0);
  end

endmodule

// File: rtl/psat_vadd.sv
module psat_vadd
  import psat_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [DATA_W-1:0]          src_a,
  input  logic [DATA_W-1:0]          src_b,
  input  logic [DATA_W-DATA_W/2-1:0] old_dst_hi,
  input  logic [7:0]                 lane_code,
  input  logic [1:0]                 form_sel,
  output logic                       out_valid,
  output logic [DATA_W-1:0]          out_result,
  output logic                       out_err
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] sum_b, sum_w, sum_sel, res_d;
  logic              is_word, code_ok, err_d;

  assign is_word = (lane_code == CODE_WORD);
  assign code_ok = (lane_code == CODE_WORD) || (lane_code == CODE_BYTE);

  psat_lane_array #(.DATA_W(DATA_W), .LANE_W(BYTE_W)) u_bytes (
    .a (src_a), .b (src_b), .y (sum_b)
  );

  psat_lane_array #(.DATA_W(DATA_W), .LANE_W(WORD_W)) u_words (
    .a (src_a), .b (src_b), .y (sum_w)
  );

  assign sum_sel = is_word ? sum_w : sum_b;

  psat_form_merge #(.DATA_W(DATA_W)) u_merge (
    .sum      (sum_sel),
    .old_hi   (old_dst_hi),
    .form_sel (form_sel),
    .code_ok  (code_ok),
    .res      (res_d),
    .err      (err_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_err    <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      out_err   <= in_valid & err_d;
      if (in_valid) out_result <= res_d;
    end
  end

  // R8: one-cycle latency and hold while idle
  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_result)));

  // R5: zero-upper form clears bits above the lower half
  p_zero_hi_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && form_sel == 2'b01) |=> out_result[DATA_W-1:HALF_W] == '0);

  // R6: keep-upper form copies the old destination
  p_keep_hi_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && form_sel == 2'b10 && code_ok)
      |=> out_result[DATA_W-1:HALF_W] == $past(old_dst_hi));

  // R7: error comes with valid and an all-zero result
  p_err_valid_r7: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (out_valid && out_result == '0));

endmodule

// File: tb/psat_vadd_test.sv
`timescale 1ns/1ps
module psat_vadd_test;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [255:0] src_a, src_b;
  logic [127:0] old_dst_hi;
  logic [7:0]   lane_code;
  logic [1:0]   form_sel;
  logic         out_valid;
  logic [255:0] out_result;
  logic         out_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  psat_vadd uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .old_dst_hi(old_dst_hi), .lane_code(lane_code), .form_sel(form_sel),
    .out_valid(out_valid), .out_result(out_result), .out_err(out_err)
  );

  function automatic logic [255:0] ref_sum(input logic [255:0] a, b, input bit word);
    logic [255:0] r = '0;
    if (word) begin
      for (int i = 0; i < 16; i++) begin
        int s = $signed(a[i*16 +: 16]) + $signed(b[i*16 +: 16]);
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        r[i*16 +: 16] = s[15:0];
      end
    end else begin
      for (int i = 0; i < 32; i++) begin
        int s = $signed(a[i*8 +: 8]) + $signed(b[i*8 +: 8]);
        if (s > 127) s = 127;
        if (s < -128) s = -128;
        r[i*8 +: 8] = s[7:0];
      end
    end
    return r;
  endfunction

  function automatic logic [255:0] ref_res(input logic [255:0] a, b,
      input logic [127:0] hi, input logic [7:0] code, input logic [1:0] form,
      output logic err);
    logic [255:0] s;
    err = !(code == 8'hEC || code == 8'hED) || form == 2'b11;
    if (err) return '0;
    s = ref_sum(a, b, code == 8'hED);
    case (form)
      2'b00:   return s;
      2'b01:   return {128'h0, s[127:0]};
      default: return {hi, s[127:0]};
    endcase
  endfunction

  task automatic chk(input string req, input logic [255:0] got, exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic string tag_of(input logic [7:0] code, input logic [1:0] form);
    if (!(code == 8'hEC || code == 8'hED) || form == 2'b11) return "R7";
    if (form == 2'b01) return "R5";
    if (form == 2'b10) return "R6";
    return (code == 8'hED) ? "R2" : "R1";
  endfunction

  // called at a falling edge; drives one op, checks at the next falling edge
  task automatic run_op(input logic [255:0] a, b, input logic [127:0] hi,
      input logic [7:0] code, input logic [1:0] form, input string req);
    logic [255:0] exp;
    logic e;
    exp = ref_res(a, b, hi, code, form, e);
    src_a = a; src_b = b; old_dst_hi = hi; lane_code = code; form_sel = form;
    in_valid = 1'b1;
    @(negedge clk);
    chk("R8 valid", {255'h0, out_valid}, 256'h1);
    chk("R7 err", {255'h0, out_err}, {255'h0, e});
    chk(req, out_result, exp);
  endtask

  function automatic logic [255:0] rnd_vec();
    logic [255:0] v;
    bit edgy = ($urandom % 3) != 0;
    for (int i = 0; i < 32; i++) begin
      if (edgy) begin
        case ($urandom % 4)
          0: v[i*8 +: 8] = 8'h7F;
          1: v[i*8 +: 8] = 8'h80;
          2: v[i*8 +: 8] = 8'h01;
          default: v[i*8 +: 8] = 8'hFF;
        endcase
      end else v[i*8 +: 8] = 8'($urandom);
    end
    return v;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [255:0] held;
    void'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 1'b0; src_a = '0; src_b = '0; old_dst_hi = '0;
    lane_code = 8'hEC; form_sel = 2'b00;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 valid", {255'h0, out_valid}, 256'h0);
    chk("R9 err", {255'h0, out_err}, 256'h0);
    chk("R9 result", out_result, 256'h0);
    rst = 1'b0;
    @(negedge clk);

    // R1: byte clamps
    run_op({32{8'h70}}, {32{8'h20}}, '0, 8'hEC, 2'b00, "R1 pos");
    chk("R1 pos value", out_result, {32{8'h7F}});
    run_op({32{8'h80}}, {32{8'hFF}}, '0, 8'hEC, 2'b00, "R1 neg");
    chk("R1 neg value", out_result, {32{8'h80}});
    // R2: word clamps
    run_op({16{16'h7FFF}}, {16{16'h0001}}, '0, 8'hED, 2'b00, "R2 pos");
    chk("R2 pos value", out_result, {16{16'h7FFF}});
    run_op({16{16'h8000}}, {16{16'h8000}}, '0, 8'hED, 2'b00, "R2 neg");
    chk("R2 neg value", out_result, {16{16'h8000}});
    // R3: no carry between lanes, exact in-range sums, per-lane clamp
    run_op({32{8'hFF}}, {32{8'h01}}, '0, 8'hEC, 2'b00, "R3 carry");
    chk("R3 carry value", out_result, 256'h0);
    run_op({16{16'h807F}}, {32{8'h01}}, '0, 8'hEC, 2'b00, "R3 mixed");
    chk("R3 mixed value", out_result, {16{16'h817F}});
    run_op({16{16'h00FF}}, {16{16'h0001}}, '0, 8'hED, 2'b00, "R3 word carry");
    chk("R3 word carry value", out_result, {16{16'h0100}});
    // R4 full width, R5 zero upper, R6 keep upper
    run_op({32{8'h11}}, {32{8'h22}}, {4{32'hDEADBEEF}}, 8'hEC, 2'b00, "R4 full");
    chk("R4 full value", out_result, {32{8'h33}});
    run_op({32{8'h11}}, {32{8'h22}}, {4{32'hDEADBEEF}}, 8'hEC, 2'b01, "R5 zero hi");
    chk("R5 value", out_result, {128'h0, {16{8'h33}}});
    run_op({32{8'h11}}, {32{8'h22}}, {4{32'hDEADBEEF}}, 8'hED, 2'b10, "R6 keep hi");
    chk("R6 value", out_result, {{4{32'hDEADBEEF}}, {16{8'h33}}});
    // R7 reserved form and unknown code
    run_op({32{8'h11}}, {32{8'h22}}, '1, 8'hEC, 2'b11, "R7 form");
    run_op({32{8'h11}}, {32{8'h22}}, '1, 8'hEE, 2'b00, "R7 code");
    run_op({32{8'h11}}, {32{8'h22}}, '1, 8'hEC, 2'b10, "R6 after err");
    // R8: idle hold
    held = out_result;
    in_valid = 1'b0; src_a = '1; src_b = '1;
    @(negedge clk);
    chk("R8 idle valid", {255'h0, out_valid}, 256'h0);
    chk("R8 idle hold", out_result, held);
    chk("R7 idle err", {255'h0, out_err}, 256'h0);
    // R9: reset after activity
    run_op({32{8'h05}}, {32{8'h05}}, '0, 8'hEC, 2'b00, "R1 pre-reset");
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk("R9 mid valid", {255'h0, out_valid}, 256'h0);
    chk("R9 mid result", out_result, 256'h0);
    rst = 1'b0;
    @(negedge clk);

    // random mix, back to back
    for (int n = 0; n < 400; n++) begin
      logic [7:0] code;
      logic [1:0] form;
      int k = $urandom % 16;
      code = (k == 0) ? 8'($urandom) : ((k % 2) ? 8'hED : 8'hEC);
      form = (($urandom % 10) == 0) ? 2'b11 : 2'($urandom % 3);
      run_op(rnd_vec(), rnd_vec(), {4{32'($urandom)}}, code, form, tag_of(code, form));
      if (($urandom % 8) == 0) begin
        held = out_result;
        in_valid = 1'b0;
        @(negedge clk);
        chk("R8 rand idle", {out_valid, out_result}, {1'b0, held});
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule